// File: doc/BRIEF.md
# Multiplexed Configuration Shadow Capture

This block listens to a time-multiplexed configuration sideband from a PCIe transaction layer and keeps a local copy of the configuration registers it carries. The sideband has no valid strobe. A 7-bit slot index and a 32-bit data word are presented together, and a level flag flips each time a new word is placed on the bus. The block sees each flip, waits a short settling delay and then stores the word. The entry it writes is chosen by the function number in index bits [6:4] and the register slot in index bits [3:0].

A second flip-flag goes with a wide status vector. On each flip of that flag the block latches the per-function device error flags and link status fields out of the vector. A combinational read port gives random access to the shadow array. Each entry has a valid bit that reads as 1 once the entry has been written. Words for functions at or above the configured function count are dropped.

Top module: `cfg_shadow_capture`

## Requirements
- R1: While `rst` is high and after its release, every entry reads `rd_valid`=0 and `rd_data`=0, and `fn_err`, `fn_link_hi` and `fn0_link` are 0, until a capture occurs.
- R2: A flip of `cfg_tgl` takes effect at a fixed point. The first rising edge that samples the new level is counted as edge 1. The entry addressed by `cfg_idx` is written with `cfg_data` at edge 4 and still holds its old contents after edge 3.
- R3: A rising flip and a falling flip of `cfg_tgl` each cause exactly one capture.
- R4: Changes on `cfg_idx` or `cfg_data` without a flip of `cfg_tgl` leave every entry unchanged.
- R5: A word whose function number (`cfg_idx[6:4]`) is greater than or equal to NUM_FUNC (default 4) is not stored. Its entry keeps reading `rd_valid`=0 and `rd_data`=0.
- R6: `rd_valid` for an entry goes to 1 at its first capture and stays at 1. `rd_data` is 0 while `rd_valid` is 0, and otherwise equals the last word stored at address `rd_addr`.
- R7: A flag level present when reset is released is not an edge. With `cfg_tgl` held at 1 through reset release, no capture occurs.
- R8: On a status capture, `fn_err[3:0]` takes `sts_vec[52:49]` and `fn0_link` takes `sts_vec[46:31]`.
- R9: On a status capture, for each function n from 1 to NUM_FUNC-1, take base b = 53+10(n-1). Then `fn_err[4n+3:4n]` takes `sts_vec[b+9:b+6]` and `fn_link_hi[5n+4:5n]` takes `sts_vec[b+5:b+1]`. `fn_link_hi[4:0]` takes `sts_vec[46:42]`. Fields for n at or above NUM_FUNC read 0.
- R10: Status outputs change only on a flip of `sts_tgl`, with the same edge-4 latency as R2. Vector changes without a flip are ignored.
- R11: A later capture to an entry overwrites the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 7 | Function number [6:4] and register slot [3:0] |
| cfg_data | input | 32 | Register contents for the current index |
| cfg_tgl | input | 1 | Flips when a new data word is presented |
| sts_vec | input | 123 | Packed status vector for all functions |
| sts_tgl | input | 1 | Flips when the status vector changes |
| rd_addr | input | 7 | Shadow entry to read, same layout as cfg_idx |
| rd_data | output | 32 | Contents of the addressed entry, 0 if not yet written |
| rd_valid | output | 1 | Addressed entry has been written since reset |
| fn_err | output | 32 | Device error flags, 4 bits per function |
| fn_link_hi | output | 40 | Link status bits 15..11, 5 bits per function |
| fn0_link | output | 16 | Full link status word of function 0 |

## Verification
The hardest case to reach is a flag that is already high when reset is released. If it were treated as an edge, the first word would be captured at once. The bench holds `cfg_tgl` at 1 through reset with a recognisable word on the bus and then waits several cycles before reading that entry. The exact capture latency is also fragile. For each table vector, the bench reads the target entry after edge 3, where it must still be stale, and after edge 4, where it must be updated. The vectors alternate rising and falling flips.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  localparam int FUNC_W    = 3;
  localparam int SLOT_W    = 4;
  localparam int IDX_W     = FUNC_W + SLOT_W;
  localparam int FUNC_MAX  = 1 << FUNC_W;
  localparam int STS_W     = 123;
  localparam int ERR_W     = 4;
  localparam int LHI_W     = 5;
  localparam int LINK_W    = 16;
  // function 0 field positions
  localparam int F0_ERR_LO  = 49;
  localparam int F0_LINK_LO = 31;
  // functions 1..7: 10-bit slices starting here
  localparam int SLICE_BASE = 53;
  localparam int SLICE_W    = 10;

  function automatic int slice_lo(input int fn);
    return SLICE_BASE + SLICE_W * (fn - 1);
  endfunction
endpackage

// File: rtl/toggle_sampler.sv
module toggle_sampler #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl,
  output logic cap
);
  logic       lvl_q, lvl_hist;
  logic [1:0] armed;
  logic [SETTLE-1:0] dly;
  logic       edge_seen;

  assign edge_seen = armed[1] & (lvl_q ^ lvl_hist);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= 1'b0;
      lvl_hist <= 1'b0;
      armed    <= '0;
      dly      <= '0;
    end else begin
      lvl_q    <= tgl;
      lvl_hist <= lvl_q;
      armed    <= {armed[0], 1'b1};
      dly      <= {dly[SETTLE-2:0], edge_seen};
    end
  end

  assign cap = dly[SETTLE-1];

  assert_edge_from_level_change_R3: assert property (@(posedge clk) disable iff (rst)
    edge_seen |-> ($past(tgl) != $past(tgl, 2)));
endmodule

// File: rtl/shadow_array.sv
module shadow_array #(
  parameter int DATA_W   = 32,
  parameter int FUNC_W   = 3,
  parameter int SLOT_W   = 4,
  parameter int NUM_FUNC = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [FUNC_W+SLOT_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [FUNC_W+SLOT_W-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);
  localparam int ADDR_W = FUNC_W + SLOT_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic              wr_ok;

  assign wr_ok = wr_en && (int'(wr_addr[ADDR_W-1 -: FUNC_W]) < NUM_FUNC);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_ok) vld[wr_addr] <= 1'b1;
  end

  assign rd_valid = vld[rd_addr];
  assign rd_data  = vld[rd_addr] ? mem[rd_addr] : '0;

  assert_ignore_high_func_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr[ADDR_W-1 -: FUNC_W]) >= NUM_FUNC) |=> $stable(vld));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((vld & $past(vld)) == $past(vld)));
endmodule

// File: rtl/status_unpack.sv
module status_unpack
  import cfg_shadow_pkg::*;
#(
  parameter int NUM_FUNC = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cap,
  input  logic [STS_W-1:0]           sts,
  output logic [FUNC_MAX*ERR_W-1:0]  err_q,
  output logic [FUNC_MAX*LHI_W-1:0]  lhi_q,
  output logic [LINK_W-1:0]          f0_link_q
);
  logic [FUNC_MAX*ERR_W-1:0] err_d;
  logic [FUNC_MAX*LHI_W-1:0] lhi_d;

  for (genvar n = 0; n < FUNC_MAX; n++) begin : g_fn
    if (n == 0) begin : g_f0
      assign err_d[0 +: ERR_W] = sts[F0_ERR_LO +: ERR_W];
      assign lhi_d[0 +: LHI_W] = sts[F0_LINK_LO + LINK_W - LHI_W +: LHI_W];
    end else if (n < NUM_FUNC) begin : g_fx
      localparam int LO = slice_lo(n);
      assign err_d[n*ERR_W +: ERR_W] = sts[LO + 6 +: ERR_W];
      assign lhi_d[n*LHI_W +: LHI_W] = sts[LO + 1 +: LHI_W];
    end else begin : g_off
      assign err_d[n*ERR_W +: ERR_W] = '0;
      assign lhi_d[n*LHI_W +: LHI_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q     <= '0;
      lhi_q     <= '0;
      f0_link_q <= '0;
    end else if (cap) begin
      err_q     <= err_d;
      lhi_q     <= lhi_d;
      f0_link_q <= sts[F0_LINK_LO +: LINK_W];
    end
  end

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ($stable(err_q) && $stable(lhi_q) && $stable(f0_link_q)));
endmodule

// File: rtl/cfg_shadow_capture.sv
module cfg_shadow_capture
  import cfg_shadow_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_FUNC = 4,
  parameter int SETTLE   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic [DATA_W-1:0]         cfg_data,
  input  logic                      cfg_tgl,
  input  logic [STS_W-1:0]          sts_vec,
  input  logic                      sts_tgl,
  input  logic [IDX_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_valid,
  output logic [FUNC_MAX*ERR_W-1:0] fn_err,
  output logic [FUNC_MAX*LHI_W-1:0] fn_link_hi,
  output logic [LINK_W-1:0]         fn0_link
);
  logic cfg_cap, sts_cap;

  toggle_sampler #(.SETTLE(SETTLE)) u_cfg_edge (
    .clk(clk), .rst(rst), .tgl(cfg_tgl), .cap(cfg_cap));

  toggle_sampler #(.SETTLE(SETTLE)) u_sts_edge (
    .clk(clk), .rst(rst), .tgl(sts_tgl), .cap(sts_cap));

  shadow_array #(
    .DATA_W(DATA_W), .FUNC_W(FUNC_W), .SLOT_W(SLOT_W), .NUM_FUNC(NUM_FUNC)
  ) u_array (
    .clk(clk), .rst(rst), .wr_en(cfg_cap), .wr_addr(cfg_idx), .wr_data(cfg_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid));

  status_unpack #(.NUM_FUNC(NUM_FUNC)) u_status (
    .clk(clk), .rst(rst), .cap(sts_cap), .sts(sts_vec),
    .err_q(fn_err), .lhi_q(fn_link_hi), .f0_link_q(fn0_link));
endmodule

// File: tb/cfg_shadow_capture_test.sv
module cfg_shadow_capture_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [6:0]   cfg_idx = '0;
  logic [31:0]  cfg_data = '0;
  logic         cfg_tgl = 1'b0;
  logic [122:0] sts_vec = '0;
  logic         sts_tgl = 1'b0;
  logic [6:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         rd_valid;
  logic [31:0]  fn_err;
  logic [39:0]  fn_link_hi;
  logic [15:0]  fn0_link;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_shadow_capture uut (
    .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_data(cfg_data), .cfg_tgl(cfg_tgl),
    .sts_vec(sts_vec), .sts_tgl(sts_tgl), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .fn_err(fn_err), .fn_link_hi(fn_link_hi), .fn0_link(fn0_link));

  // {exp_stored, idx[6:0], data[31:0]}
  localparam logic [39:0] VEC [8] = '{
    {1'b1, 7'h00, 32'hA5A5_0001},
    {1'b1, 7'h05, 32'h1234_5678},
    {1'b1, 7'h1F, 32'hDEAD_BEEF},
    {1'b1, 7'h2A, 32'h0F0F_F0F0},
    {1'b0, 7'h43, 32'hCAFE_0043},
    {1'b1, 7'h3C, 32'h8000_0001},
    {1'b0, 7'h7E, 32'hFFFF_FFFF},
    {1'b1, 7'h11, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [6:0] a,
                          input logic v, input logic [31:0] d);
    rd_addr = a;
    #1;
    chk(req, {63'd0, rd_valid}, {63'd0, v});
    chk(req, {32'd0, rd_data}, {32'd0, d});
  endtask

  // drive a word with a flag flip; check stale after edge 3, written after edge 4
  task automatic put_word(input logic [6:0] idx, input logic [31:0] d,
                          input logic [31:0] old_d, input logic old_v, input logic stored,
                          input string req);
    @(negedge clk);
    cfg_idx = idx; cfg_data = d; cfg_tgl = ~cfg_tgl; rd_addr = idx;
    repeat (3) @(posedge clk);
    #1;
    read_chk(req, idx, old_v, old_d);
    @(posedge clk);
    #1;
    if (stored) read_chk(req, idx, 1'b1, d);
    else        read_chk("R5", idx, old_v, old_d);
    repeat (4) @(posedge clk);
  endtask

  function automatic logic [122:0] make_sts(input int seed);
    logic [122:0] v;
    for (int i = 0; i < 123; i++) v[i] = ((i * 7 + seed) % 3) == 0;
    return v;
  endfunction

  task automatic sts_expect(input logic [122:0] v, output logic [31:0] e,
                            output logic [39:0] l, output logic [15:0] w);
    e = '0; l = '0;
    e[3:0] = v[52:49];
    l[4:0] = v[46:42];
    w = v[46:31];
    for (int n = 1; n < 4; n++) begin
      int b = 53 + 10 * (n - 1);
      e[4*n +: 4] = v[b + 6 +: 4];
      l[5*n +: 5] = v[b + 1 +: 5];
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] e;
    logic [39:0] l;
    logic [15:0] w;
    logic [122:0] s;

    // R7: flag high through reset release with a word on the bus
    cfg_tgl = 1'b1; cfg_idx = 7'h02; cfg_data = 32'h7777_7777;
    repeat (3) @(posedge clk);
    #1;
    read_chk("R1", 7'h02, 1'b0, 32'h0);
    chk("R1", {32'd0, fn_err}, 64'd0);
    chk("R1", {24'd0, fn_link_hi}, 64'd0);
    @(negedge clk); rst = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    read_chk("R7", 7'h02, 1'b0, 32'h0);
    read_chk("R1", 7'h00, 1'b0, 32'h0);
    chk("R1", {48'd0, fn0_link}, 64'd0);

    // table walk: R2 latency, R3 alternating flip direction, R5 dropped functions
    for (int i = 0; i < 8; i++) begin
      put_word(VEC[i][38:32], VEC[i][31:0], 32'h0, 1'b0, VEC[i][39],
               (i % 2) ? "R3" : "R2");
    end
    for (int i = 0; i < 8; i++) begin
      read_chk("R6", VEC[i][38:32], VEC[i][39], VEC[i][39] ? VEC[i][31:0] : 32'h0);
    end

    // R11: overwrite an existing entry
    put_word(7'h05, 32'hBBBB_0005, 32'h1234_5678, 1'b1, 1'b1, "R11");

    // R4: bus changes without a flip
    @(negedge clk);
    cfg_idx = 7'h05; cfg_data = 32'h0BAD_0BAD;
    repeat (10) @(posedge clk);
    #1;
    read_chk("R4", 7'h05, 1'b1, 32'hBBBB_0005);
    cfg_idx = 7'h06;
    repeat (10) @(posedge clk);
    #1;
    read_chk("R4", 7'h06, 1'b0, 32'h0);

    // R8 / R9 / R10 status capture with latency
    s = make_sts(1);
    @(negedge clk);
    sts_vec = s; sts_tgl = ~sts_tgl;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", {32'd0, fn_err}, 64'd0);
    @(posedge clk);
    #1;
    sts_expect(s, e, l, w);
    chk("R8", {32'd0, fn_err}, {32'd0, e});
    chk("R8", {48'd0, fn0_link}, {48'd0, w});
    chk("R9", {24'd0, fn_link_hi}, {24'd0, l});

    // R10: vector change without flip is ignored
    @(negedge clk);
    sts_vec = make_sts(2);
    repeat (10) @(posedge clk);
    #1;
    chk("R10", {32'd0, fn_err}, {32'd0, e});
    chk("R10", {24'd0, fn_link_hi}, {24'd0, l});

    // second flip (other direction) picks up the new vector
    s = make_sts(2);
    @(negedge clk);
    sts_tgl = ~sts_tgl;
    repeat (4) @(posedge clk);
    #1;
    sts_expect(s, e, l, w);
    chk("R9", {32'd0, fn_err}, {32'd0, e});
    chk("R9", {24'd0, fn_link_hi}, {24'd0, l});
    chk("R8", {48'd0, fn0_link}, {48'd0, w});

    // R1: reset clears shadow and status
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    #1;
    read_chk("R1", 7'h05, 1'b0, 32'h0);
    chk("R1", {32'd0, fn_err}, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule